// File: doc/BRIEF.md
# Random Number Source Controller

This block turns a raw serial noise stream into 32-bit random words that software collects by polling. A single control register picks one of four post-processing chains: the bits pass straight through, pass through a 32-bit linear feedback mixer, pass through a pair-based bias corrector, or pass through the mixer and then the corrector. The same register also holds a collection enable and a deterministic test mode. In test mode, an internal 16-bit shift-register generator stands in for the external noise, so that the output after reset can be reproduced.

Conditioned bits are shifted into a word one at a time, oldest bit first. When 32 bits have been gathered, the word is latched and a ready flag is raised in the status register. Software polls that flag and then reads the word. The read clears the flag and restarts collection. The read port is a simple combinational register port. The write side has one control register only.

Top module: `rng_source_ctrl`

## Requirements
- R1: The post-processing select sits at control bits 9:8 (0 = raw bits). The control register reads back at offset 0x000 with bits 11:8 as written and all other bits zero. Words assemble first bit in as the most significant bit, newest bit at bit 0.
- R2: Select 1 passes each bit through a 32-bit right-shifting Galois mixer. The mixer starts at seed 0x00000001 and uses polynomial mask 0x80200003. Its output bit is f = state[0] XOR input, and its next state is (state >> 1) XOR (f ? mask : 0). The mixer steps only on a collected bit.
- R3: Select 2 groups the bits into non-overlapping pairs. The pair 10 gives 1, the pair 01 gives 0, and the pairs 00 and 11 give nothing.
- R4: Select 3 feeds the mixer output of R2 into the pair corrector of R3.
- R5: Control bit 10 enables collection. While it is 0, no bit is collected and a partly built word is kept.
- R6: Control bit 11 selects test mode. In test mode the noise input is ignored. The source is then bit 0 of a 16-bit right-shifting Galois generator with seed 0xACE1 and mask 0xB400, which steps on every cycle after reset.
- R7: After 32 conditioned bits, the word appears at offset 0x050 and bit 0 of the status register at offset 0x054 is set. The flag and the word update on the edge that takes in the 32nd bit.
- R8: While the flag is set, no bits are collected and the value register holds its word. A read of offset 0x050 while the flag is set clears the flag on the next edge and restarts collection. The value register keeps returning the last word.
- R9: A control write whose select differs from the current one discards the partial word and any half pair, and clears the flag. No bit is collected in that cycle.
- R10: After reset the control register, the flag and the value register are zero. Addresses other than 0x000, 0x050 and 0x054 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| noise_bit | input | 1 | Raw noise stream, one bit per cycle |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| rd_en | input | 1 | Read strobe (a read of 0x050 consumes the word) |
| rd_addr | input | 12 | Byte offset for the read port |
| rd_data | output | 32 | Combinational read data |

## Verification
The hardest situation to reach from the ports is a change of select that lands in the middle of a word, while the corrector holds half a pair and a finished word is still unread. The stimulus gets there by leaving a word unread and then rewriting the select. The stimulus also changes the select partway through a random-noise run. The reproducibility of test mode is checked by running the same schedule after two resets, with opposite noise streams, and comparing the words.

// File: rtl/rng_pkg.sv
package rng_pkg;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_VALUE = 12'h050;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 12'h054;

  localparam logic [31:0] MIX_POLY = 32'h8020_0003;
  localparam logic [31:0] MIX_SEED = 32'h0000_0001;
  localparam logic [15:0] TST_POLY = 16'hB400;
  localparam logic [15:0] TST_SEED = 16'hACE1;

  typedef enum logic [1:0] {
    PP_RAW  = 2'd0,
    PP_MIX  = 2'd1,
    PP_VN   = 2'd2,
    PP_BOTH = 2'd3
  } pp_sel_e;

  // one step of a right-shifting Galois register
  function automatic logic [31:0] galois_step(input logic [31:0] s,
                                              input logic fb,
                                              input logic [31:0] poly);
    return (s >> 1) ^ (fb ? poly : 32'h0);
  endfunction

  // pair corrector: {emit, bit}
  function automatic logic [1:0] vn_pair(input logic first, input logic second);
    return {first ^ second, first};
  endfunction
endpackage

// File: rtl/rng_test_src.sv
module rng_test_src #(
  parameter int          W    = 16,
  parameter logic [W-1:0] POLY = rng_pkg::TST_POLY,
  parameter logic [W-1:0] SEED = rng_pkg::TST_SEED
) (
  input  logic clk,
  input  logic rst_n,
  output logic bit_o
);
  logic [W-1:0] st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= SEED;
    else st_q <= W'(rng_pkg::galois_step(32'(st_q), st_q[0], 32'(POLY)));
  end

  assign bit_o = st_q[0];

  // R6
  tsrc_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n) st_q != '0);
endmodule

// File: rtl/rng_mixer.sv
module rng_mixer #(
  parameter int           W    = 32,
  parameter logic [W-1:0] POLY = rng_pkg::MIX_POLY,
  parameter logic [W-1:0] SEED = rng_pkg::MIX_SEED
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  input  logic bit_i,
  output logic bit_o
);
  logic [W-1:0] st_q;
  logic         fb_w;

  assign fb_w  = st_q[0] ^ bit_i;
  assign bit_o = fb_w;

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= SEED;
    else if (step_i) st_q <= W'(rng_pkg::galois_step(32'(st_q), fb_w, 32'(POLY)));
  end

  // R2
  mix_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !step_i |=> $stable(st_q));
endmodule

// File: rtl/rng_whitener.sv
module rng_whitener (
  input  logic clk,
  input  logic rst_n,
  input  logic flush_i,
  input  logic step_i,
  input  logic bit_i,
  output logic out_vld_o,
  output logic out_bit_o
);
  logic have_q, first_q;
  logic [1:0] pair_w;

  assign pair_w    = rng_pkg::vn_pair(first_q, bit_i);
  assign out_vld_o = step_i & have_q & pair_w[1];
  assign out_bit_o = pair_w[0];

  always_ff @(posedge clk) begin
    if (!rst_n || flush_i) begin
      have_q  <= 1'b0;
      first_q <= 1'b0;
    end else if (step_i) begin
      have_q  <= ~have_q;
      if (!have_q) first_q <= bit_i;
    end
  end

  // R3
  wh_pair_done_chk: assert property (@(posedge clk) disable iff (!rst_n) out_vld_o |=> !have_q);
  // R9
  wh_flush_chk: assert property (@(posedge clk) disable iff (!rst_n) flush_i |=> !have_q);
endmodule

// File: rtl/rng_word_asm.sv
module rng_word_asm #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  input  logic              rd_clr_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-2:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              valid_q;
  logic [WORD_W-1:0] word_q;
  logic              done_w;

  assign done_w = bit_vld_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q <= '0; cnt_q <= '0; valid_q <= 1'b0; word_q <= '0;
    end else if (flush_i) begin
      cnt_q <= '0; valid_q <= 1'b0;
    end else begin
      if (rd_clr_i) valid_q <= 1'b0;
      if (done_w) begin
        word_q  <= {sh_q, bit_i};
        valid_q <= 1'b1;
        cnt_q   <= '0;
      end else if (bit_vld_i) begin
        sh_q  <= {sh_q[WORD_W-3:0], bit_i};
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign valid_o = valid_q;
  assign word_o  = word_q;

  // R7
  asm_complete_chk: assert property (@(posedge clk) disable iff (!rst_n) done_w && !flush_i |=> valid_q);
  // R8
  asm_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_clr_i && !bit_vld_i |=> !valid_q);
  // R8
  asm_word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !done_w |=> $stable(word_q));
  // R9
  asm_flush_chk: assert property (@(posedge clk) disable iff (!rst_n) flush_i |=> !valid_q && cnt_q == '0);
endmodule

// File: rtl/rng_source_ctrl.sv
module rng_source_ctrl #(
  parameter int WORD_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        noise_bit,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  input  logic        rd_en,
  input  logic [11:0] rd_addr,
  output logic [31:0] rd_data
);
  import rng_pkg::*;

  pp_sel_e sel_q;
  logic    en_q, test_q;

  // named internal events
  logic sel_change_w, collect_w, rd_clr_w;
  logic src_bit_w, tst_bit_w, mix_bit_w, stage1_w;
  logic wh_vld_w, wh_bit_w, asm_vld_w, asm_bit_w;
  logic valid_w;
  logic [WORD_W-1:0] value_w;
  logic unused_cfg_bits;

  assign unused_cfg_bits = ^{cfg_wdata[31:12], cfg_wdata[7:0]};

  assign sel_change_w = cfg_we && (cfg_wdata[9:8] != sel_q);
  assign collect_w    = en_q && !valid_w && !sel_change_w;
  assign rd_clr_w     = rd_en && (rd_addr == OFF_VALUE) && valid_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= PP_RAW; en_q <= 1'b0; test_q <= 1'b0;
    end else if (cfg_we) begin
      sel_q  <= pp_sel_e'(cfg_wdata[9:8]);
      en_q   <= cfg_wdata[10];
      test_q <= cfg_wdata[11];
    end
  end

  rng_test_src u_tsrc (.clk(clk), .rst_n(rst_n), .bit_o(tst_bit_w));

  assign src_bit_w = test_q ? tst_bit_w : noise_bit;

  rng_mixer u_mix (
    .clk(clk), .rst_n(rst_n),
    .step_i(collect_w && sel_q[0]),
    .bit_i(src_bit_w), .bit_o(mix_bit_w)
  );

  assign stage1_w = sel_q[0] ? mix_bit_w : src_bit_w;

  rng_whitener u_wh (
    .clk(clk), .rst_n(rst_n), .flush_i(sel_change_w),
    .step_i(collect_w && sel_q[1]), .bit_i(stage1_w),
    .out_vld_o(wh_vld_w), .out_bit_o(wh_bit_w)
  );

  assign asm_vld_w = collect_w && (sel_q[1] ? wh_vld_w : 1'b1);
  assign asm_bit_w = sel_q[1] ? wh_bit_w : stage1_w;

  rng_word_asm #(.WORD_W(WORD_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .flush_i(sel_change_w),
    .bit_vld_i(asm_vld_w), .bit_i(asm_bit_w), .rd_clr_i(rd_clr_w),
    .valid_o(valid_w), .word_o(value_w)
  );

  always_comb begin
    unique case (rd_addr)
      OFF_CTRL:  rd_data = {20'h0, test_q, en_q, sel_q, 8'h0};
      OFF_VALUE: rd_data = 32'(value_w);
      OFF_STAT:  rd_data = {31'h0, valid_w};
      default:   rd_data = 32'h0;
    endcase
  end

  // R5
  noise_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !en_q |=> $stable(value_w));
  // R8
  full_no_collect_chk: assert property (@(posedge clk) disable iff (!rst_n) valid_w && !rd_clr_w && !sel_change_w |=> valid_w && $stable(value_w));
endmodule

// File: tb/sim_rng_source_ctrl.sv
module sim_rng_source_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_CTRL = 12'h000, A_VAL = 12'h050, A_STAT = 12'h054;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, rd_en = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [11:0] rd_addr = A_STAT;
  logic [31:0] rd_data;
  logic pat_bit = 1'b0, rnd_bit = 1'b0, use_rnd = 1'b0, inv_rnd = 1'b0;
  logic noise_bit;
  int n_tests = 0, n_fail = 0, cyc = 0;

  assign noise_bit = use_rnd ? (rnd_bit ^ inv_rnd) : pat_bit;

  rng_source_ctrl u0 (.clk(clk), .rst_n(rst_n), .noise_bit(noise_bit), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  int unsigned m_sel, m_en, m_test, m_valid, m_word, m_mix, m_tst;
  bit m_have, m_first;
  bit q[$];

  function automatic int unsigned exp_read(input logic [11:0] a);
    if (a == A_CTRL) return (m_test << 11) | (m_en << 10) | (m_sel << 8);
    if (a == A_VAL) return m_word;
    if (a == A_STAT) return m_valid;
    return 0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  always @(negedge clk) rnd_bit <= 1'($urandom);

  always @(posedge clk) begin
    bit b, emit, flush;
    cyc++;
    if (!rst_n) begin
      m_sel = 0; m_en = 0; m_test = 0; m_valid = 0; m_word = 0;
      m_mix = 32'h1; m_tst = 32'hACE1; m_have = 0; m_first = 0; q.delete();
    end else begin
      b = m_test != 0 ? m_tst[0] : noise_bit;
      flush = cfg_we && (int'(cfg_wdata[9:8]) != m_sel);
      if (flush) begin
        q.delete(); m_have = 0; m_valid = 0;
      end else if (rd_en && rd_addr == A_VAL && m_valid != 0) begin
        m_valid = 0;
      end else if (m_en != 0 && m_valid == 0) begin
        emit = 1;
        if (m_sel % 2 == 1) begin
          b = b ^ m_mix[0];
          m_mix = m_mix / 2;
          if (b) m_mix = m_mix ^ 32'h8020_0003;
        end
        if (m_sel >= 2) begin
          if (!m_have) begin m_have = 1; m_first = b; emit = 0; end
          else begin m_have = 0; emit = (m_first != b); b = m_first; end
        end
        if (emit) begin
          q.push_back(b);
          if (q.size() == 32) begin
            m_word = 0;
            foreach (q[i]) m_word = m_word * 2 + int'(q[i]);
            m_valid = 1; q.delete();
          end
        end
      end
      if (m_tst % 2 == 1) m_tst = (m_tst / 2) ^ 32'hB400; else m_tst = m_tst / 2;
      if (cfg_we) begin
        m_sel = int'(cfg_wdata[9:8]); m_en = int'(cfg_wdata[10]); m_test = int'(cfg_wdata[11]);
      end
      #1;
      chk(rd_addr == A_VAL ? "R7 value" : (rd_addr == A_STAT ? "R7 status" : "R1 ctrl"),
          rd_data, exp_read(rd_addr));
    end
  end

  task automatic set_ctrl(input int sel, input bit en, input bit tst);
    @(negedge clk);
    cfg_we = 1; cfg_wdata = 32'((int'(tst) << 11) | (int'(en) << 10) | (sel << 8)) | 32'hF0F0_F0FF;
    @(negedge clk);
    cfg_we = 0; cfg_wdata = '0;
  endtask

  task automatic peek(input logic [11:0] a, output logic [31:0] d);
    rd_addr = a; #1 d = rd_data; rd_addr = A_STAT;
  endtask

  task automatic rd_val(output logic [31:0] d);
    @(negedge clk);
    rd_en = 1; rd_addr = A_VAL; #1 d = rd_data;
    @(negedge clk);
    rd_en = 0; rd_addr = A_STAT;
  endtask

  task automatic do_reset;
    rst_n = 0; cfg_we = 0; rd_en = 0; rd_addr = A_STAT;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d, w1, w2;
    do_reset;
    // R10 reset state and unmapped space
    peek(A_CTRL, d); chk("R10 ctrl reset", d, 32'h0);
    peek(A_STAT, d); chk("R10 status reset", d, 32'h0);
    peek(A_VAL, d);  chk("R10 value reset", d, 32'h0);
    peek(12'h010, d); chk("R10 unmapped", d, 32'h0);

    // R1 raw path, MSB first
    set_ctrl(0, 1, 0);
    peek(A_CTRL, d); chk("R1 ctrl readback", d, 32'h0000_0400);
    for (int i = 31; i >= 0; i--) begin pat_bit = w1[0] ^ 1'b0; pat_bit = 32'hA5C3_3C96 >> i; @(negedge clk); end
    peek(A_STAT, d); chk("R7 valid after 32 bits", d, 32'h1);
    peek(A_VAL, d);  chk("R1 raw word", d, 32'hA5C3_3C96);
    // R8 no collection while full
    use_rnd = 1; wait_cyc(40);
    peek(A_VAL, d); chk("R8 word held while full", d, 32'hA5C3_3C96);
    rd_val(d); chk("R8 read data", d, 32'hA5C3_3C96);
    peek(A_STAT, d); chk("R8 read clears flag", d, 32'h0);
    peek(A_VAL, d);  chk("R8 last word after read", d, 32'hA5C3_3C96);

    // R5 enable off keeps state
    wait_cyc(10);
    set_ctrl(0, 0, 0);
    wait_cyc(50);
    peek(A_STAT, d); chk("R5 no collection when disabled", d, 32'h0);
    peek(A_VAL, d);  chk("R5 value untouched", d, 32'hA5C3_3C96);
    set_ctrl(0, 1, 0);
    wait_cyc(40);
    peek(A_STAT, d); chk("R5 resumes", d, 32'h1);

    // R9 select change with a full word pending
    set_ctrl(2, 1, 0);
    peek(A_STAT, d); chk("R9 flag cleared by select change", d, 32'h0);
    // R3 whitener on a known pair stream
    use_rnd = 0;
    for (int i = 31; i >= 0; i--) begin
      bit b;
      b = 1'(32'h3C5A_F00D >> i);
      if (i % 3 == 0) begin pat_bit = 1; @(negedge clk); pat_bit = 1; @(negedge clk); end
      if (i % 5 == 0) begin pat_bit = 0; @(negedge clk); pat_bit = 0; @(negedge clk); end
      pat_bit = b; @(negedge clk); pat_bit = ~b; @(negedge clk);
    end
    peek(A_STAT, d); chk("R3 valid", d, 32'h1);
    peek(A_VAL, d);  chk("R3 whitened word", d, 32'h3C5A_F00D);
    rd_val(d);

    // R2 mixer path
    use_rnd = 1;
    set_ctrl(1, 1, 0);
    wait_cyc(60);
    peek(A_STAT, d); chk("R2 valid", d, 32'h1);
    peek(A_VAL, d);  chk("R2 mixed word", d, m_word);
    rd_val(d);
    // R9 change mid-word
    wait_cyc(13);
    set_ctrl(3, 1, 0);
    wait_cyc(400);
    peek(A_STAT, d); chk("R4 valid", d, 32'h1);
    peek(A_VAL, d);  chk("R4 mix+whiten word", d, m_word);
    rd_val(d);

    // R6 deterministic test mode across two resets
    do_reset; inv_rnd = 0;
    set_ctrl(3, 1, 1); wait_cyc(600);
    peek(A_STAT, d); chk("R6 valid run1", d, 32'h1);
    peek(A_VAL, w1);
    do_reset; inv_rnd = 1;
    set_ctrl(3, 1, 1); wait_cyc(600);
    peek(A_VAL, w2);
    chk("R6 reproducible word", w2, w1);
    rd_val(d);
    set_ctrl(0, 1, 1); wait_cyc(40);
    peek(A_VAL, d); chk("R6 raw test-source word", d, m_word);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule